// File: doc/BRIEF.md
# Busy-Gated SPI Command Frame Engine

This block runs one command frame towards an SPI peripheral that reports readiness on a BUSY line. A host hands it an opcode, a write length, a read length and an eight-byte buffer. The block lowers chip-select, shifts out the opcode, then runs a single data phase whose length is the larger of the two lengths. It returns each received byte into the buffer slot it came from, and raises chip-select again.

The order of chip-select and BUSY depends on whether the peripheral is believed to be asleep. An awake peripheral is waited on with chip-select high. A sleeping one is woken by lowering chip-select first and then waiting for BUSY to drop. The block remembers a sleep command once its frame closes. The serial shifter is reached through a byte-exchange handshake: one start pulse carries a transmit byte, and a done pulse returns the received byte.

Top module: `spi_cmd_xfer`

## Requirements
- R1: While the sleep flag is clear, chip-select (csN, active low) stays high until BUSY has been sampled low, and falls only afterwards.
- R2: While the sleep flag is set, an accepted request lowers csN at once without regard to BUSY. The engine then waits for BUSY low, clears the flag, and only then starts the opcode byte.
- R3: The first byte exchanged in a frame carries the opcode. The byte received during it leaves the buffer unchanged.
- R4: The data phase exchanges exactly max(W, R) bytes, where W and R are the clamped lengths. Byte n carries buffer byte n when n < W and 0x00 otherwise. Buffer byte n occupies reqBuf/rspBuf bits [8n+7:8n].
- R5: For n < R the byte received at data index n replaces buffer byte n. Bytes received at n >= R are dropped, and those slots keep the value loaded with the request.
- R6: done is a one-cycle pulse in the cycle after the last exchange completes, with csN already high. engBusy is high from the cycle after acceptance through the done cycle and low in the cycle after it.
- R7: A frame whose opcode equals SLEEP_OPCODE (default 0x84) sets the sleep flag in the cycle after done. Any other completed frame leaves the flag clear.
- R8: With W = R = 0 the frame exchanges the opcode byte alone.
- R9: Length inputs above 8 are treated as 8.
- R10: A request raised while engBusy is high is ignored: it starts no frame and leaves the running frame untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request strobe, taken only while idle |
| reqOpcode | input | 8 | Command opcode |
| reqWlen | input | LEN_W | Bytes to write from the buffer |
| reqRlen | input | LEN_W | Bytes to read into the buffer |
| reqBuf | input | 8*BUF_BYTES | Buffer contents loaded at acceptance |
| rspBuf | output | 8*BUF_BYTES | Buffer contents, updated with received bytes |
| engBusy | output | 1 | Frame in progress |
| done | output | 1 | End-of-frame pulse |
| sleepFlag | output | 1 | Peripheral believed asleep |
| busyIn | input | 1 | Peripheral BUSY line |
| csN | output | 1 | Chip-select, active low |
| byteStart | output | 1 | Start one byte exchange |
| byteTx | output | 8 | Byte to shift out |
| byteDone | input | 1 | Byte exchange finished |
| byteRx | input | 8 | Byte shifted in |

## Verification
The bench builds the block with its defaults: an eight-byte buffer, four-bit lengths and opcode 0x84 as the sleep command. Four-bit lengths allow requests of 9 to 15, which reach the clamp. Random lengths cover every ordering of write and read counts, including zero on either side. Held BUSY periods and a sleep command followed by a further frame reach both chip-select orderings.

// File: rtl/spx_pkg.sv
package spx_pkg;
  typedef struct packed {
    logic load;     // capture request into datapath
    logic capture;  // store received byte, advance index
    logic selOp;    // transmit mux selects opcode
  } spxStrobe_t;

  typedef enum logic [2:0] {
    S_IDLE, S_READY_WAIT, S_WAKE_WAIT, S_OP_GO, S_OP_WAIT, S_DAT_GO, S_DAT_WAIT, S_END
  } spxState_t;
endpackage

// File: rtl/spx_datapath.sv
module spx_datapath
  import spx_pkg::*;
#(
  parameter int BUF_BYTES = 8,
  parameter int LEN_W = 4,
  parameter logic [7:0] SLEEP_OPCODE = 8'h84,
  parameter logic [7:0] NOP_BYTE = 8'h00
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  spxStrobe_t             strobe,
  input  logic [7:0]             reqOpcode,
  input  logic [LEN_W-1:0]       reqWlen,
  input  logic [LEN_W-1:0]       reqRlen,
  input  logic [8*BUF_BYTES-1:0] reqBuf,
  input  logic [7:0]             byteRx,
  output logic [7:0]             txByte,
  output logic [8*BUF_BYTES-1:0] rspBuf,
  output logic                   noData,
  output logic                   lastData,
  output logic                   sleepOp
);
  localparam int IDX_W = $clog2(BUF_BYTES + 1);
  localparam int PTR_W = (BUF_BYTES > 1) ? $clog2(BUF_BYTES) : 1;

  logic [7:0]       bufMem [BUF_BYTES];
  logic [7:0]       opcReg;
  logic [IDX_W-1:0] wlReg, rlReg, idx, total;
  logic [IDX_W-1:0] wlenC, rlenC;
  logic [PTR_W-1:0] ptr;

  always_comb begin
    wlenC = (32'(reqWlen) > BUF_BYTES) ? IDX_W'(BUF_BYTES) : IDX_W'(reqWlen);
    rlenC = (32'(reqRlen) > BUF_BYTES) ? IDX_W'(BUF_BYTES) : IDX_W'(reqRlen);
    total = (wlReg > rlReg) ? wlReg : rlReg;
    ptr = idx[PTR_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opcReg <= '0;
      wlReg  <= '0;
      rlReg  <= '0;
      idx    <= '0;
      for (int i = 0; i < BUF_BYTES; i++) bufMem[i] <= '0;
    end else if (strobe.load) begin
      opcReg <= reqOpcode;
      wlReg  <= wlenC;
      rlReg  <= rlenC;
      idx    <= '0;
      for (int i = 0; i < BUF_BYTES; i++) bufMem[i] <= reqBuf[8*i +: 8];
    end else if (strobe.capture) begin
      if (idx < rlReg) bufMem[ptr] <= byteRx;
      idx <= idx + 1'b1;
    end
  end

  always_comb begin
    if (strobe.selOp)      txByte = opcReg;
    else if (idx < wlReg)  txByte = bufMem[ptr];
    else                   txByte = NOP_BYTE;
  end

  assign noData   = (total == '0);
  assign lastData = (idx == total - 1'b1);
  assign sleepOp  = (opcReg == SLEEP_OPCODE);

  for (genvar g = 0; g < BUF_BYTES; g++) begin : g_flat
    assign rspBuf[8*g +: 8] = bufMem[g];
  end
endmodule

// File: rtl/spx_ctrl.sv
module spx_ctrl
  import spx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       busyIn,
  input  logic       byteDone,
  input  logic       noData,
  input  logic       lastData,
  input  logic       sleepOp,
  output spxStrobe_t strobe,
  output logic       csN,
  output logic       byteStart,
  output logic       engBusy,
  output logic       done,
  output logic       sleepFlag
);
  spxState_t state, nextState;

  always_comb begin
    nextState = state;
    strobe    = '0;
    byteStart = 1'b0;
    case (state)
      S_IDLE: if (reqValid) begin
        strobe.load = 1'b1;
        nextState = sleepFlag ? S_WAKE_WAIT : S_READY_WAIT;
      end
      S_READY_WAIT: if (!busyIn) nextState = S_OP_GO;
      S_WAKE_WAIT:  if (!busyIn) nextState = S_OP_GO;
      S_OP_GO: begin
        strobe.selOp = 1'b1;
        byteStart = 1'b1;
        nextState = S_OP_WAIT;
      end
      S_OP_WAIT: begin
        strobe.selOp = 1'b1;
        if (byteDone) nextState = noData ? S_END : S_DAT_GO;
      end
      S_DAT_GO: begin
        byteStart = 1'b1;
        nextState = S_DAT_WAIT;
      end
      S_DAT_WAIT: if (byteDone) begin
        strobe.capture = 1'b1;
        nextState = lastData ? S_END : S_DAT_GO;
      end
      S_END: nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      sleepFlag <= 1'b0;
    end else begin
      state <= nextState;
      if (state == S_WAKE_WAIT && !busyIn) sleepFlag <= 1'b0;
      else if (state == S_END)             sleepFlag <= sleepOp;
    end
  end

  assign csN = !(state inside {S_WAKE_WAIT, S_OP_GO, S_OP_WAIT, S_DAT_GO, S_DAT_WAIT});
  assign engBusy = (state != S_IDLE);
  assign done = (state == S_END);
endmodule

// File: rtl/spi_cmd_xfer.sv
module spi_cmd_xfer
  import spx_pkg::*;
#(
  parameter int BUF_BYTES = 8,
  parameter int LEN_W = 4,
  parameter logic [7:0] SLEEP_OPCODE = 8'h84,
  parameter logic [7:0] NOP_BYTE = 8'h00
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  input  logic [7:0]             reqOpcode,
  input  logic [LEN_W-1:0]       reqWlen,
  input  logic [LEN_W-1:0]       reqRlen,
  input  logic [8*BUF_BYTES-1:0] reqBuf,
  output logic [8*BUF_BYTES-1:0] rspBuf,
  output logic                   engBusy,
  output logic                   done,
  output logic                   sleepFlag,
  input  logic                   busyIn,
  output logic                   csN,
  output logic                   byteStart,
  output logic [7:0]             byteTx,
  input  logic                   byteDone,
  input  logic [7:0]             byteRx
);
  spxStrobe_t strobe;
  logic noData, lastData, sleepOp;

  spx_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .busyIn(busyIn),
    .byteDone(byteDone), .noData(noData), .lastData(lastData), .sleepOp(sleepOp),
    .strobe(strobe), .csN(csN), .byteStart(byteStart), .engBusy(engBusy),
    .done(done), .sleepFlag(sleepFlag)
  );

  spx_datapath #(
    .BUF_BYTES(BUF_BYTES), .LEN_W(LEN_W), .SLEEP_OPCODE(SLEEP_OPCODE), .NOP_BYTE(NOP_BYTE)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqOpcode(reqOpcode),
    .reqWlen(reqWlen), .reqRlen(reqRlen), .reqBuf(reqBuf), .byteRx(byteRx),
    .txByte(byteTx), .rspBuf(rspBuf), .noData(noData), .lastData(lastData),
    .sleepOp(sleepOp)
  );
endmodule

// File: rtl/spi_cmd_xfer_chk.sv
module spi_cmd_xfer_chk (
  input logic clk,
  input logic rstN,
  input logic csN,
  input logic busyIn,
  input logic sleepFlag,
  input logic byteStart,
  input logic engBusy,
  input logic done
);
  assert_cs_after_ready_R1: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(csN) && !sleepFlag) |-> !$past(busyIn));

  assert_wake_cs_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sleepFlag) |-> !csN);

  assert_start_in_frame_R3: assert property (@(posedge clk) disable iff (!rstN)
    byteStart |-> (!csN && engBusy));

  assert_single_start_R4: assert property (@(posedge clk) disable iff (!rstN)
    byteStart |=> !byteStart);

  assert_cs_release_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> csN);

  assert_busy_drop_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !engBusy);

  assert_sleep_set_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sleepFlag) |-> $past(done));
endmodule

bind spi_cmd_xfer spi_cmd_xfer_chk chk_i (
  .clk(clk), .rstN(rstN), .csN(csN), .busyIn(busyIn), .sleepFlag(sleepFlag),
  .byteStart(byteStart), .engBusy(engBusy), .done(done)
);

// File: tb/spi_cmd_xfer_tb_top.sv
module spi_cmd_xfer_tb_top;
  localparam int BUF_BYTES = 8;
  localparam int LEN_W = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [7:0] reqOpcode = '0;
  logic [LEN_W-1:0] reqWlen = '0, reqRlen = '0;
  logic [8*BUF_BYTES-1:0] reqBuf = '0;
  logic [8*BUF_BYTES-1:0] rspBuf;
  logic engBusy, done, sleepFlag, csN, byteStart;
  logic busyIn = 1'b0;
  logic [7:0] byteTx;
  logic byteDone = 1'b0;
  logic [7:0] byteRx = '0;
  logic [7:0] rxBase = '0;

  int nChecks = 0;
  int nFails = 0;
  bit sleepExp = 0;

  always #10 clk = ~clk;

  spi_cmd_xfer dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOpcode(reqOpcode),
    .reqWlen(reqWlen), .reqRlen(reqRlen), .reqBuf(reqBuf), .rspBuf(rspBuf),
    .engBusy(engBusy), .done(done), .sleepFlag(sleepFlag), .busyIn(busyIn),
    .csN(csN), .byteStart(byteStart), .byteTx(byteTx), .byteDone(byteDone),
    .byteRx(byteRx)
  );

  // byte shifter model
  logic [7:0] txLog [16];
  int nStart = 0;
  int totalStarts = 0;
  int cyc = 0;
  int lastDoneCyc = 0;
  int dly = 0;
  logic pend = 1'b0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    byteDone <= 1'b0;
    if (byteStart) begin
      if (nStart < 16) txLog[nStart] <= byteTx;
      nStart <= nStart + 1;
      totalStarts <= totalStarts + 1;
      pend <= 1'b1;
      dly <= int'($urandom_range(2, 0));
    end else if (pend) begin
      if (dly == 0) begin
        pend <= 1'b0;
        byteDone <= 1'b1;
        byteRx <= rxBase + 8'(nStart - 1);
        lastDoneCyc <= cyc;
      end else dly <= dly - 1;
    end else if (csN) nStart <= 0;
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int clampLen(input int l);
    return (l > BUF_BYTES) ? BUF_BYTES : l;
  endfunction

  function automatic logic [7:0] expTx(input logic [63:0] orig, input int n, input int w);
    return (n < w) ? orig[8*n +: 8] : 8'h00;
  endfunction

  function automatic logic [63:0] expBuf(input logic [63:0] orig, input int r, input logic [7:0] base);
    logic [63:0] e = orig;
    for (int n = 0; n < r; n++) e[8*n +: 8] = base + 8'(n + 1);
    return e;
  endfunction

  task automatic runFrame(input logic [7:0] opc, input int w, input int r,
                          input int busyHold, input bit intrude);
    logic [63:0] orig = {$urandom, $urandom};
    int cw = clampLen(w), cr = clampLen(r);
    int tot = (cw > cr) ? cw : cr;
    int startsBefore, waitCnt;
    bit wasSleep = sleepExp;
    @(negedge clk);
    reqOpcode = opc; reqWlen = LEN_W'(w); reqRlen = LEN_W'(r); reqBuf = orig;
    rxBase = 8'($urandom);
    reqValid = 1'b1;
    busyIn = (busyHold > 0);
    startsBefore = totalStarts;
    @(negedge clk);
    reqValid = 1'b0;
    if (busyHold > 0) begin
      repeat (busyHold) @(negedge clk);
      if (wasSleep) begin
        check(csN == 1'b0, "R2 cs low while asleep and busy", csN, 0);
        check(sleepFlag == 1'b1, "R2 flag held until ready", sleepFlag, 1);
      end else begin
        check(csN == 1'b1, "R1 cs high while busy", csN, 1);
      end
      check(nStart == 0, "R1/R2 no byte before ready", nStart, 0);
      busyIn = 1'b0;
    end
    if (intrude) begin
      reqOpcode = 8'h5A; reqWlen = 4'd7; reqRlen = 4'd7;
      reqValid = 1'b1;
      @(negedge clk);
      reqValid = 1'b0;
    end
    waitCnt = 0;
    while (!done && waitCnt < 2000) begin
      @(negedge clk);
      waitCnt++;
    end
    if (!done) begin
      check(0, "R6 watchdog waiting for done", 0, 1);
      return;
    end
    check(csN == 1'b1, "R6 cs high at done", csN, 1);
    check(cyc == lastDoneCyc + 2, "R6 done right after last byte", cyc - lastDoneCyc, 2);
    check(engBusy == 1'b1, "R6 busy through done", engBusy, 1);
    check(nStart == 1 + tot, (tot == 0) ? "R8 opcode-only frame" : "R4/R9 byte count",
          nStart, 1 + tot);
    check(txLog[0] == opc, "R3 opcode first", txLog[0], opc);
    for (int n = 0; n < tot && n < 15; n++)
      check(txLog[n+1] == expTx(orig, n, cw), "R4 data byte", txLog[n+1], expTx(orig, n, cw));
    check(rspBuf == expBuf(orig, cr, rxBase), "R5/R3 buffer contents",
          rspBuf, expBuf(orig, cr, rxBase));
    @(negedge clk);
    check(engBusy == 1'b0, "R6 idle after done", engBusy, 0);
    sleepExp = (opc == 8'h84);
    check(sleepFlag == sleepExp, sleepExp ? "R7 sleep flag set" : "R7/R2 sleep flag clear",
          sleepFlag, sleepExp);
    if (intrude) begin
      repeat (4) @(negedge clk);
      check(totalStarts - startsBefore == 1 + tot, "R10 request during frame ignored",
            totalStarts - startsBefore, 1 + tot);
      check(engBusy == 1'b0, "R10 no second frame", engBusy, 0);
    end
  endtask

  initial begin
    int rs;
    rs = int'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(csN == 1'b1 && engBusy == 1'b0 && done == 1'b0 && sleepFlag == 1'b0 && byteStart == 1'b0,
          "R6 reset state", {csN, engBusy, done, sleepFlag, byteStart}, 5'b10000);
    rstN = 1'b1;
    @(negedge clk);
    runFrame(8'h0D, 3, 0, 0, 0);     // write only
    runFrame(8'h1D, 0, 5, 0, 0);     // read only, NOP padding
    runFrame(8'h11, 0, 0, 0, 0);     // R8
    runFrame(8'h8F, 12, 15, 0, 0);   // R9 clamp
    runFrame(8'h0E, 8, 2, 3, 0);     // R1 awake busy hold
    runFrame(8'h84, 1, 0, 0, 0);     // R7 sleep command
    runFrame(8'h12, 2, 4, 5, 0);     // R2 wake path
    runFrame(8'h02, 4, 6, 2, 1);     // R10 intrude
    for (int k = 0; k < 40; k++) begin
      logic [7:0] op = ($urandom_range(9, 0) == 0) ? 8'h84 : 8'($urandom);
      runFrame(op, int'($urandom_range(15, 0)), int'($urandom_range(15, 0)),
               int'($urandom_range(3, 0)), ($urandom_range(4, 0) == 0));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule